// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This block is a hardware sequencer that searches the capability chain of a configuration space for one capability type. A requester pulses `start_i` with an 8-bit target type code on `cap_id_i`. The walker then issues single-DWORD reads on a simple request/acknowledge read port and follows the chain. When the walk ends it reports one of three results: the capability was found at a given byte offset, it is not present, or the chain was malformed and the walk was cut short.

The walk has three steps. First the walker reads the status DWORD at byte offset 04h and checks bit 20, the flag that says a capability list exists. Next it reads the root pointer from bits [7:0] of the DWORD at offset 34h. It then reads one DWORD per structure. In each of these, bits [7:0] hold the type code and bits [15:8] hold the pointer to the next structure. Every pointer has its two low bits forced to zero. A pointer below 40h, including 00h, ends the chain. The structures lie between 40h and FFh, so no valid chain can hold more than 48 of them. A walk that reaches that many structures without ending is taken to be a loop. It is aborted and `loop_err_o` is raised.

The controller has four states. `ST_IDLE` moves to `ST_STATUS` when `start_i` is seen. `ST_STATUS` moves to `ST_ROOT` if the list flag is set, or back to `ST_IDLE` with a miss if it is clear. `ST_ROOT` moves to `ST_HEADER` if the root pointer is at or above 40h, or back to `ST_IDLE` with a miss if it is not. `ST_HEADER` returns to `ST_IDLE` in three cases: with a hit when the type code matches, with a miss when the next pointer ends the chain, and with a loop error when the hop limit is reached. In any other case it stays in `ST_HEADER` and advances to the next pointer. Each state that reads waits for `rd_ack_i` before it takes any of its transitions.

Top module: `cap_chain_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `found_o`, `loop_err_o` and `rd_req_o` are 0 and `offset_o` is 00h.
- R2: The first read of every walk is at byte address 04h. If bit 20 of the returned DWORD is 0, the walk ends after that single read with `done_o`=1 and `found_o`=0.
- R3: The second read is at 34h. The root pointer is bits [7:0] of the returned DWORD with bits [1:0] forced to 0.
- R4: Each structure costs exactly one read, at its aligned pointer. Bits [7:0] of that DWORD are the type code and bits [15:8] are the next pointer, with bits [1:0] of the next pointer forced to 0.
- R5: When a structure's type code equals the target, the walk ends with `found_o`=1, `done_o`=1 and `offset_o` equal to that structure's aligned byte address.
- R6: A root or next pointer that is below 40h after alignment (00h included) ends the walk with `found_o`=0, `loop_err_o`=0, `offset_o`=00h and no further reads.
- R7: If 48 structures have been read without a match and without the chain ending, the walk ends with `loop_err_o`=1 and `found_o`=0. A walk therefore never makes more than 50 reads.
- R8: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` is seen, so any response latency is accepted. Only one read is outstanding at a time, and no request is made while idle.
- R9: `start_i` is accepted only when `busy_o`=0. A start pulse during a walk has no effect on that walk's reads or result. `done_o`, `found_o`, `loop_err_o` and `offset_o` hold their values until the next accepted start.
- R10: Every read address has bits [1:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; only accepted while idle |
| cap_id_i | input | 8 | Type code to search for, captured at start |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 8 | Byte address of the requested DWORD |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | The last walk has ended; held until the next start |
| found_o | output | 1 | The target was found |
| loop_err_o | output | 1 | The walk was aborted at the hop limit |
| offset_o | output | 8 | Byte offset of the structure that matched |

## Verification
Each result appears one clock edge after the acknowledge that decides it. `done_o` and the result flags are registered on the same edge that returns the controller to `ST_IDLE`. `busy_o` rises on the edge that accepts `start_i`. The next request appears in the cycle after an acknowledge, so the number of acknowledged reads is the walk's cycle cost: one for a missing list, two for a bad root, and two plus the number of structures otherwise. The bench responds on falling edges with latencies of zero to several cycles. It waits for `done_o` and samples on a falling edge. It then compares the logged read addresses and the read count with the values worked out from the chain it loaded.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STATUS,
        ST_ROOT,
        ST_HEADER
    } walk_state_e;

    typedef struct packed {
        logic [7:0] next_ptr;
        logic [7:0] type_code;
    } cap_hdr_t;

    localparam logic [7:0] STATUS_ADDR  = 8'h04;
    localparam logic [7:0] ROOT_ADDR    = 8'h34;
    localparam int         LIST_FLAG    = 20;

endpackage

// File: rtl/cap_ptr_filter.sv
module cap_ptr_filter #(
    parameter int         ADDR_W      = 8,
    parameter int         ALIGN_BITS  = 2,
    parameter logic [7:0] REGION_BASE = 8'h40
) (
    input  logic [ADDR_W-1:0] raw_i,
    output logic [ADDR_W-1:0] aligned_o,
    output logic              in_region_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'((1 << ALIGN_BITS) - 1));
    localparam logic [ADDR_W-1:0] BASE       = (ADDR_W)'(REGION_BASE);

    always_comb begin
        aligned_o   = raw_i & ALIGN_MASK;
        in_region_o = (aligned_o >= BASE);
    end
endmodule

// File: rtl/cap_hop_counter.sv
module cap_hop_counter #(
    parameter int MAX_HOPS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX_HOPS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_HOPS - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step_i && count_q != LAST_VAL) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_o = (count_q == LAST_VAL);
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
    import cap_walk_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter int         ID_W        = 8,
    parameter logic [7:0] REGION_BASE = 8'h40,
    parameter int         MAX_HOPS    = (256 - 64) / 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ID_W-1:0]   cap_id_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic              loop_err_o,
    output logic [ADDR_W-1:0] offset_o
);
    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [ID_W-1:0]   target_q;
    cap_hdr_t          hdr;
    logic [ADDR_W-1:0] raw_ptr, aligned_ptr;
    logic              ptr_ok, hop_last;
    logic              accept, ev_hit, ev_miss, ev_loop, ev_advance;
    logic              unused_data_bits;

    assign hdr              = cap_hdr_t'(rd_data_i[15:0]);
    assign unused_data_bits = ^{rd_data_i[DATA_W-1:LIST_FLAG+1], rd_data_i[LIST_FLAG-1:16]};
    assign accept           = (state_q == ST_IDLE) && start_i;

    always_comb begin
        raw_ptr = (state_q == ST_ROOT) ? rd_data_i[ADDR_W-1:0] : hdr.next_ptr[ADDR_W-1:0];
    end

    cap_ptr_filter #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (2),
        .REGION_BASE(REGION_BASE)
    ) u_filter (
        .raw_i      (raw_ptr),
        .aligned_o  (aligned_ptr),
        .in_region_o(ptr_ok)
    );

    cap_hop_counter #(
        .MAX_HOPS(MAX_HOPS)
    ) u_hops (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .step_i (ev_advance),
        .last_o (hop_last)
    );

    // Next-state and walk events
    always_comb begin
        state_d    = state_q;
        ptr_d      = ptr_q;
        ev_hit     = 1'b0;
        ev_miss    = 1'b0;
        ev_loop    = 1'b0;
        ev_advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_STATUS;
            end
            ST_STATUS: begin
                if (rd_ack_i) begin
                    if (rd_data_i[LIST_FLAG]) begin
                        state_d = ST_ROOT;
                    end else begin
                        ev_miss = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_ROOT: begin
                if (rd_ack_i) begin
                    if (ptr_ok) begin
                        ptr_d   = aligned_ptr;
                        state_d = ST_HEADER;
                    end else begin
                        ev_miss = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HEADER: begin
                if (rd_ack_i) begin
                    if (hdr.type_code == target_q) begin
                        ev_hit  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!ptr_ok) begin
                        ev_miss = 1'b1;
                        state_d = ST_IDLE;
                    end else if (hop_last) begin
                        ev_loop = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        ev_advance = 1'b1;
                        ptr_d      = aligned_ptr;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (accept) target_q <= cap_id_i;
        end
    end

    // Result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            found_o    <= 1'b0;
            loop_err_o <= 1'b0;
            offset_o   <= '0;
        end else if (accept) begin
            done_o     <= 1'b0;
            found_o    <= 1'b0;
            loop_err_o <= 1'b0;
            offset_o   <= '0;
        end else if (ev_hit) begin
            done_o   <= 1'b1;
            found_o  <= 1'b1;
            offset_o <= ptr_q;
        end else if (ev_miss) begin
            done_o <= 1'b1;
        end else if (ev_loop) begin
            done_o     <= 1'b1;
            loop_err_o <= 1'b1;
        end
    end

    // Read port
    always_comb begin
        rd_req_o  = 1'b0;
        rd_addr_o = '0;
        unique case (state_q)
            ST_IDLE:   rd_req_o = 1'b0;
            ST_STATUS: begin rd_req_o = 1'b1; rd_addr_o = STATUS_ADDR[ADDR_W-1:0]; end
            ST_ROOT:   begin rd_req_o = 1'b1; rd_addr_o = ROOT_ADDR[ADDR_W-1:0];   end
            ST_HEADER: begin rd_req_o = 1'b1; rd_addr_o = ptr_q;                   end
            default:   rd_req_o = 1'b0;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/cap_walk_checker.sv
module cap_walk_checker #(
    parameter int ADDR_W   = 8,
    parameter int MAX_HOPS = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              found_o,
    input logic              loop_err_o,
    input logic [ADDR_W-1:0] offset_o
);
    logic [15:0] ack_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_cnt <= '0;
        else if (!busy_o && start_i) ack_cnt <= '0;
        else if (rd_ack_i && busy_o) ack_cnt <= ack_cnt + 1'b1;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o); // R8
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_addr_o[1:0] == 2'b00); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(found_o) && $stable(offset_o) && $stable(loop_err_o)); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && !done_o); // R9
    AST_FOUND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o || loop_err_o) |-> done_o && !busy_o); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(found_o && loop_err_o)); // R7
    AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cnt <= 16'(MAX_HOPS + 2)); // R7
    AST_HIT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> offset_o >= ADDR_W'(8'h40)); // R6
endmodule

bind cap_chain_walker cap_walk_checker #(
    .ADDR_W  (ADDR_W),
    .MAX_HOPS(MAX_HOPS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .found_o   (found_o),
    .loop_err_o(loop_err_o),
    .offset_o  (offset_o)
);

// File: tb/cap_chain_walker_tb.sv
module cap_chain_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cap_id = 8'h00;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, done, found, loop_err;
    logic [7:0]  offset;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    int wait_cnt = 0;
    int reads = 0;
    logic [31:0] cfg [0:63];
    logic [7:0]  addr_log [0:63];

    always #10 clk = ~clk;

    cap_chain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cap_id_i(cap_id),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .found_o(found), .loop_err_o(loop_err), .offset_o(offset)
    );

    // Read responder: one ack pulse per request after 'lat' idle cycles
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack   <= 1'b0;
            wait_cnt <= lat;
        end else if (rd_req) begin
            if (wait_cnt == 0) begin
                rd_ack  <= 1'b1;
                rd_data <= cfg[rd_addr[7:2]];
                if (reads < 64) addr_log[reads] = rd_addr;
                reads = reads + 1;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 64; i++) cfg[i] = 32'h0;
        cfg[1] = 32'h0010_0000;
    endtask

    task automatic set_hdr(input logic [7:0] a, input logic [7:0] id, input logic [7:0] nxt);
        cfg[a[7:2]] = {16'h0, nxt, id};
    endtask

    task automatic walk(input logic [7:0] target);
        reads = 0;
        @(negedge clk);
        start  = 1'b1;
        cap_id = target;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    endtask

    task automatic load_chain();
        clear_cfg();
        cfg[13] = 32'h0000_0050;
        set_hdr(8'h50, 8'h01, 8'h70);
        set_hdr(8'h70, 8'h05, 8'h48);
        set_hdr(8'h48, 8'h10, 8'h00);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !found && !loop_err && !rd_req, "R1 idle flags", {busy, done, found, loop_err, rd_req}, 0);
        chk(offset == 8'h00, "R1 offset", offset, 0);
    endtask

    task automatic t_no_list();
        clear_cfg();
        cfg[1] = 32'hFFEF_FFFF;
        walk(8'h01);
        chk(done && !found && !loop_err, "R2 miss flags", {done, found, loop_err}, 3'b100);
        chk(reads == 1, "R2 read count", reads, 1);
        chk(addr_log[0] == 8'h04, "R2 status addr", addr_log[0], 8'h04);
    endtask

    task automatic t_hit(input int l);
        lat = l;
        load_chain();
        walk(8'h05);
        chk(done && found && !loop_err, "R5 hit flags", {done, found, loop_err}, 3'b110);
        chk(offset == 8'h70, "R5 offset", offset, 8'h70);
        chk(reads == 4, "R8 read count with latency", reads, 4);
        chk(addr_log[1] == 8'h34, "R3 root addr", addr_log[1], 8'h34);
        chk(addr_log[2] == 8'h50 && addr_log[3] == 8'h70, "R4 header addrs",
            {addr_log[2], addr_log[3]}, 16'h5070);
        lat = 0;
    endtask

    task automatic t_end_of_chain();
        load_chain();
        walk(8'h11);
        chk(done && !found && !loop_err && offset == 0, "R6 end flags", {done, found, loop_err}, 3'b100);
        chk(reads == 5 && addr_log[4] == 8'h48, "R6 read count", reads, 5);
    endtask

    task automatic t_align();
        clear_cfg();
        cfg[13] = 32'hABCD_EF53;
        set_hdr(8'h50, 8'h09, 8'h73);
        set_hdr(8'h70, 8'h05, 8'h00);
        walk(8'h05);
        chk(addr_log[2] == 8'h50, "R3 root masked", addr_log[2], 8'h50);
        chk(addr_log[3] == 8'h70, "R10 next masked", addr_log[3], 8'h70);
        chk(found && offset == 8'h70, "R4 masked hit", offset, 8'h70);
    endtask

    task automatic t_low_ptr();
        clear_cfg();
        cfg[13] = 32'h0000_003C;
        walk(8'h00);
        chk(done && !found && reads == 2, "R6 low root", reads, 2);
        clear_cfg();
        cfg[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h01, 8'h3F);
        walk(8'h77);
        chk(done && !found && reads == 3, "R6 low next", reads, 3);
    endtask

    task automatic t_loop();
        clear_cfg();
        cfg[13] = 32'h0000_0040;
        set_hdr(8'h40, 8'h01, 8'h44);
        set_hdr(8'h44, 8'h02, 8'h40);
        walk(8'h99);
        chk(done && loop_err && !found, "R7 loop flags", {done, loop_err, found}, 3'b110);
        chk(reads == 50, "R7 read count", reads, 50);
    endtask

    task automatic t_hold_and_ignore();
        lat = 6;
        load_chain();
        reads = 0;
        @(negedge clk);
        start = 1'b1; cap_id = 8'h05;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; cap_id = 8'h10;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        chk(found && offset == 8'h70, "R9 start during walk ignored", offset, 8'h70);
        chk(reads == 4, "R9 read count", reads, 4);
        repeat (20) @(negedge clk);
        chk(done && found && offset == 8'h70 && !busy, "R9 result held", offset, 8'h70);
        lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) addr_log[i] = 8'h00;
        clear_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_list();
        t_hit(0);
        t_hit(5);
        t_end_of_chain();
        t_align();
        t_low_ptr();
        t_loop();
        t_hold_and_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule